// File: doc/BRIEF.md
# Width-Aligned Receive FIFO

This block sits between a serial receive shifter and the processor side of a host port. Each time the shifter finishes a word, it offers that word, always 24 bits wide with the payload aligned to the top. The block first clears the bytes that the current data width does not use. It then stores the word in a ten-entry first-in-first-out buffer. The processor core and a DMA engine each have their own read strobe. A read on either strobe takes the oldest word, and the word appears on a registered data output on the next clock.

The width select chooses 8, 16 or 24 bits. The most significant byte, or the top two bytes, or all three bytes are kept, and every other bit is stored as zero. Status comes out on three flags:

- a not-empty flag, which falls only once the last stored word has been taken;
- a full flag;
- a sticky overrun flag, which records a word that arrived when there was no space.

A synchronous clear input models stop mode and the software and per-block resets. It empties the buffer in the same way as the asynchronous reset.

Top module: `rx_word_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released, the buffer is empty. `not_empty_o`, `full_o` and `overrun_o` are 0 and `rd_data_o` is 0.
- R2: A high `clear_i` at a clock edge empties the buffer, clears `overrun_o` and sets `rd_data_o` to 0. It takes priority over any write or read in the same cycle.
- R3: With `mode_i` = 2'b00 (8-bit), a stored word keeps `wr_data_i[23:16]`, and bits 15:0 are stored as zero.
- R4: With `mode_i` = 2'b01 (16-bit), a stored word keeps `wr_data_i[23:8]`, and bits 7:0 are stored as zero.
- R5: With `mode_i` = 2'b10 or 2'b11 (24-bit), all 24 bits are stored unchanged.
- R6: Words come out in the order they were written. The buffer holds exactly 10 words, and `full_o` is high exactly when 10 words are held.
- R7: A read strobe (`rd_i` or `dma_rd_i`) on a non-empty buffer removes the oldest word and presents it on `rd_data_o` after that clock edge. If both strobes are high in one cycle, only one word is removed.
- R8: `not_empty_o` stays high until the read that removes the last stored word.
- R9: A write while 10 words are held and no read is accepted is discarded, and `overrun_o` is set. `overrun_o` then stays set until a reset or a clear.
- R10: A read and a write in the same cycle while full are both accepted. The buffer stays full and `overrun_o` does not change.
- R11: A read on an empty buffer leaves `rd_data_o` and all flags unchanged.
- R12: A read and a write in the same cycle on a partly filled buffer keep the occupancy constant. Order is preserved across any number of pointer wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clear_i | input | 1 | Synchronous empty (stop mode or software reset) |
| mode_i | input | 2 | Width select: 00 = 8-bit, 01 = 16-bit, 10/11 = 24-bit |
| wr_i | input | 1 | Word from the shifter is valid this cycle |
| wr_data_i | input | 24 | Shifter word, payload aligned to the top |
| rd_i | input | 1 | Core read strobe |
| dma_rd_i | input | 1 | DMA read strobe |
| rd_data_o | output | 24 | Last word read |
| not_empty_o | output | 1 | At least one word is held |
| full_o | output | 1 | Ten words are held |
| overrun_o | output | 1 | Sticky: a word was dropped |

## Verification
The bench sweeps all four width codes with several bit patterns. A masking error would leak low bytes into 8- or 16-bit words, or clip 24-bit words. It fills the buffer to exactly ten words, writes while full both with and without a read, and runs many read-and-write cycles so that the pointers wrap several times. A wrong wrap at 9 or a wrong full count would return words out of order, lose a word, or drop one falsely. It also reads while empty, strobes both read inputs together, and clears in the middle of traffic. A design that got these wrong would change the data output, pop twice, or let a same-cycle write survive the clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_24  = 2'b10,
    WID_24X = 2'b11
  } width_e;

  // number of upper bytes retained for a width code
  function automatic int unsigned kept_bytes(input width_e w, input int unsigned total);
    case (w)
      WID_8:   kept_bytes = 1;
      WID_16:  kept_bytes = 2;
      default: kept_bytes = total;
    endcase
  endfunction
endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rxf_lane_mask.sv
module rxf_lane_mask
  import rxf_pkg::*;
#(
  parameter int unsigned BYTES = 3
) (
  input  logic [1:0]         mode_i,
  input  logic [BYTES*8-1:0] data_i,
  output logic [BYTES*8-1:0] data_o
);
  int unsigned keep;

  always_comb begin
    keep = kept_bytes(width_e'(mode_i), BYTES);
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign data_o[b*8 +: 8] = (b >= int'(BYTES - keep)) ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/rxf_wrap_ptr.sv
module rxf_wrap_ptr #(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i)                        ptr_d = '0;
    else if (adv_i && ptr_q == LAST)  ptr_d = '0;
    else if (adv_i)                   ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned BYTES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic [1:0]           mode_i,
  input  logic                 wr_i,
  input  logic [BYTES*8-1:0]   wr_data_i,
  input  logic                 rd_i,
  input  logic                 dma_rd_i,
  output logic [BYTES*8-1:0]   rd_data_o,
  output logic                 not_empty_o,
  output logic                 full_o,
  output logic                 overrun_o
);
  localparam int unsigned W     = BYTES * 8;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             rst_sync_n;
  logic [W-1:0]     masked;
  logic [PTR_W-1:0] wptr, rptr;
  logic [W-1:0]     mem [DEPTH];

  logic [CNT_W-1:0] count_q, count_d;
  logic [W-1:0]     rdat_q, rdat_d;
  logic             ovr_q, ovr_d;
  logic             rd_any, pop_ok, push_ok, is_full;

  rxf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxf_lane_mask #(.BYTES(BYTES)) u_mask (
    .mode_i (mode_i),
    .data_i (wr_data_i),
    .data_o (masked)
  );

  // accept logic: a pop frees a slot in the same cycle
  always_comb begin
    is_full = (count_q == FULL_CNT);
    rd_any  = rd_i | dma_rd_i;
    pop_ok  = rd_any && (count_q != '0) && !clear_i;
    push_ok = wr_i && (!is_full || pop_ok) && !clear_i;
  end

  rxf_wrap_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (clear_i),
    .adv_i (push_ok),
    .ptr_o (wptr)
  );

  rxf_wrap_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (clear_i),
    .adv_i (pop_ok),
    .ptr_o (rptr)
  );

  // storage array: no reset needed, qualified by occupancy
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= masked;
  end

  always_comb begin
    count_d = count_q;
    rdat_d  = rdat_q;
    ovr_d   = ovr_q;
    if (clear_i) begin
      count_d = '0;
      rdat_d  = '0;
      ovr_d   = 1'b0;
    end else begin
      if (push_ok && !pop_ok)      count_d = count_q + 1'b1;
      else if (pop_ok && !push_ok) count_d = count_q - 1'b1;
      if (pop_ok)                  rdat_d  = mem[rptr];
      if (wr_i && !push_ok)        ovr_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      count_q <= '0;
      rdat_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      rdat_q  <= rdat_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rd_data_o   = rdat_q;
  assign not_empty_o = (count_q != '0);
  assign full_o      = is_full;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear_i,
  input logic         wr_i,
  input logic         rd_i,
  input logic         dma_rd_i,
  input logic [W-1:0] rd_data_o,
  input logic         not_empty_o,
  input logic         full_o,
  input logic         overrun_o
);
  logic rd_any;
  assign rd_any = rd_i | dma_rd_i;

  p_clear_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!not_empty_o && !full_o && !overrun_o && rd_data_o == '0));

  p_full_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> not_empty_o);

  p_ne_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty_o && !rd_any && !clear_i) |=> not_empty_o);

  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && wr_i && !rd_any && !clear_i) |=> (overrun_o && full_o));

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !clear_i) |=> overrun_o);

  p_full_rw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && wr_i && rd_any && !clear_i) |=> (full_o && overrun_o == $past(overrun_o)));

  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty_o && rd_any && !wr_i && !clear_i) |=> ($stable(rd_data_o) && !not_empty_o));
endmodule

bind rx_word_fifo rxf_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .clear_i     (clear_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .dma_rd_i    (dma_rd_i),
  .rd_data_o   (rd_data_o),
  .not_empty_o (not_empty_o),
  .full_o      (full_o),
  .overrun_o   (overrun_o)
);

// File: tb/rx_word_fifo_test.sv
`timescale 1ns/1ps
module rx_word_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear_i;
  logic [1:0]  mode_i;
  logic        wr_i;
  logic [23:0] wr_data_i;
  logic        rd_i;
  logic        dma_rd_i;
  logic [23:0] rd_data_o;
  logic        not_empty_o, full_o, overrun_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [23:0] q[$];
  logic [23:0] exp_rd;
  logic        exp_ovr;

  always #2.5 clk = ~clk;

  rx_word_fifo uut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .mode_i(mode_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_i(rd_i), .dma_rd_i(dma_rd_i),
    .rd_data_o(rd_data_o), .not_empty_o(not_empty_o), .full_o(full_o),
    .overrun_o(overrun_o)
  );

  function automatic logic [23:0] trim(input logic [1:0] m, input logic [23:0] d);
    case (m)
      2'b00:   trim = d & 24'hFF0000;
      2'b01:   trim = d & 24'hFFFF00;
      default: trim = d;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "rd_data", rd_data_o, exp_rd);
    chk(req, "not_empty", {23'd0, not_empty_o}, {23'd0, q.size() != 0});
    chk(req, "full", {23'd0, full_o}, {23'd0, q.size() == 10});
    chk(req, "overrun", {23'd0, overrun_o}, {23'd0, exp_ovr});
  endtask

  // called at a falling edge; applies one cycle of stimulus and checks after it
  task automatic step(input bit wr, input logic [23:0] d, input logic [1:0] m,
                      input bit rd, input bit dma, input bit clr, input string req);
    bit pop, push;
    wr_i = wr; wr_data_i = d; mode_i = m; rd_i = rd; dma_rd_i = dma; clear_i = clr;
    if (clr) begin
      q.delete(); exp_ovr = 0; exp_rd = '0;
    end else begin
      pop  = (rd || dma) && q.size() > 0;
      push = wr && (q.size() < 10 || pop);
      if (wr && !push) exp_ovr = 1;
      if (pop) exp_rd = q.pop_front();
      if (push) q.push_back(trim(m, d));
    end
    @(posedge clk);
    @(negedge clk);
    wr_i = 0; rd_i = 0; dma_rd_i = 0; clear_i = 0;
    compare_all(req);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    q.delete(); exp_ovr = 0; exp_rd = '0;
    compare_all("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all("R1");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clear_i = 0; mode_i = 0; wr_i = 0; wr_data_i = 0; rd_i = 0; dma_rd_i = 0;
    @(negedge clk);
    do_reset();

    // R3 R4 R5: all width codes, several patterns, alternating read strobes
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 5; i++) begin
        logic [23:0] pat;
        pat = 24'hA55AC3 ^ (24'h3C1E0F * (i + 1)) ^ (24'h010101 << m);
        step(1, pat, m[1:0], 0, 0, 0, (m == 0) ? "R3" : (m == 1) ? "R4" : "R5");
      end
      for (int i = 0; i < 5; i++)
        step(0, 0, m[1:0], i[0], !i[0], 0, (m == 0) ? "R3" : (m == 1) ? "R4" : "R5");
    end
    step(1, 24'hFFFFFF, 2'b00, 0, 0, 0, "R3");
    step(0, 0, 2'b00, 1, 0, 0, "R3");
    step(1, 24'hFFFFFF, 2'b01, 0, 0, 0, "R4");
    step(0, 0, 2'b00, 1, 0, 0, "R4");

    // R6: fill exactly to ten
    for (int i = 0; i < 10; i++) step(1, 24'h100000 + 24'(i * 24'h1111), 2'b10, 0, 0, 0, "R6");
    // R9: write at full without read is dropped, overrun sticks
    step(1, 24'hDEAD01, 2'b10, 0, 0, 0, "R9");
    step(0, 0, 2'b10, 0, 0, 0, "R9");
    // R10: read and write at full
    step(1, 24'hBEEF02, 2'b10, 1, 0, 0, "R10");
    step(1, 24'hBEEF03, 2'b10, 0, 1, 0, "R10");
    // R7: both strobes pop a single word
    step(0, 0, 2'b10, 1, 1, 0, "R7");
    // R8: drain, flag falls only on last read
    for (int i = 0; i < 9; i++) step(0, 0, 2'b10, 1, 0, 0, "R8");
    // R11: reads on empty leave everything as is
    step(0, 0, 2'b10, 1, 0, 0, "R11");
    step(0, 0, 2'b10, 1, 1, 0, "R11");
    // R2: clear clears overrun
    step(0, 0, 2'b10, 0, 0, 1, "R2");

    // R12: steady read+write with five held, many wraps
    for (int i = 0; i < 5; i++) step(1, 24'h200000 + 24'(i), 2'b10, 0, 0, 0, "R12");
    for (int i = 0; i < 40; i++)
      step(1, 24'h300000 + 24'(i * 24'h0101), 2'(i % 4), 1, i[1], 0, "R12");
    // R11 with write on empty after drain: read fails, write lands
    for (int i = 0; i < 5; i++) step(0, 0, 2'b10, 1, 0, 0, "R12");
    step(1, 24'h7A7A7A, 2'b10, 1, 0, 0, "R11");
    step(0, 0, 2'b10, 0, 1, 0, "R11");

    // R2: clear beats same-cycle write and read
    for (int i = 0; i < 4; i++) step(1, 24'h400000 + 24'(i), 2'b10, 0, 0, 0, "R2");
    step(1, 24'h55AA55, 2'b10, 1, 1, 1, "R2");
    step(0, 0, 2'b10, 1, 0, 0, "R2");

    // R1: asynchronous reset during traffic
    for (int i = 0; i < 12; i++) step(1, 24'h600000 + 24'(i), 2'b01, 0, 0, 0, "R9");
    step(0, 0, 2'b10, 1, 0, 0, "R7");
    do_reset();
    step(1, 24'h123456, 2'b10, 0, 0, 0, "R6");
    step(0, 0, 2'b10, 0, 1, 0, "R6");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule